// File: doc/BRIEF.md
# Station Address Filter with Table Loader

This block holds a table of sixteen 48-bit station addresses together with a 16-bit enable mask, and decides for each incoming destination address whether the frame is for this station. On command it fills the table by walking a list of load records in memory. It reads one 16-bit word at a time over a simple request/valid master port. After the last record it fetches a new enable mask from the word that follows.

Classification is purely combinational. The receive path presents the 48-bit destination address with three mode bits: promiscuous, accept-all-multicast and broadcast-enable. In the same cycle it gets back an accept decision and a multicast or broadcast flag. While the controller is held in reset, a host read port can return any table entry one 16-bit word at a time.

Address byte 0 is the first byte on the wire. It sits in `dstAddr[7:0]`, and its bit 0 (`dstAddr[0]`) marks a group address. Table entries are packed the same way.

Top module: `addr_cam_filter`

## Requirements
- R1: After the hardware reset the block is idle: `loadBusy`, `loadDone` and `memReq` are low, all entries read back as zero and the enable mask is zero, so with every mode bit off an all-zero destination is rejected.
- R2: A load record is four 16-bit words. Word 0 is never requested. Words 1, 2 and 3 are requested in that order and fill entry bits [15:0], [31:16] and [47:32]. The low byte of each word is the lower-numbered address byte.
- R3: A load reads one record for every unit in `descCount[4:0]`. Bits above bit 4 are ignored, and a count whose low five bits are zero reads no record. In narrow mode (`wideMode`=0) word k of a record is at record base + 2k and the next record starts 8 bytes further on.
- R4: In wide mode (`wideMode`=1) every 16-bit value sits in a 4-byte slot. Word k is at record base + 4k, and the next record starts 16 bytes further on.
- R5: After the last record, one more word is requested at the current pointer and loaded as the enable mask. Then `loadBusy` falls and `loadDone` is high for exactly one cycle, in the same cycle that `loadBusy` is first low.
- R6: Each load writes from entry 0 upward. Entries beyond the records of that load keep their earlier contents.
- R7: A load with more than 16 records stops after entry 15. The mask is then read at the pointer just after the sixteenth record.
- R8: Entry i takes part in matching only while enable mask bit i is 1.
- R9: With promiscuous mode on, any destination with bit 0 clear is accepted with both flags low. Promiscuous mode alone does not accept a group address.
- R10: With accept-all-multicast on, any destination with bit 0 set is accepted with `isMulti` high. This takes priority over the broadcast rule, so an all-ones address then carries `isMulti` and not `isBcast`.
- R11: With broadcast-enable on, the all-ones address is accepted with `isBcast` high. No other group address is accepted by this rule.
- R12: A destination that none of the earlier rules accepts is accepted, with both flags low, exactly when it equals an enabled entry. Otherwise it is rejected and both flags are low.
- R13: While `ctrlInReset` is 1, `rdData` returns bits [16w+15:16w] of the entry selected by `camPtr`, where w is `rdWordSel` from 0 to 2. A `rdWordSel` of 3 returns 0, and while `ctrlInReset` is 0 the port returns 0.
- R14: Only one memory request is outstanding at a time. `memReq` and `memAddr` hold until `memValid`, requests occur only during a load, and a `loadStart` during a load is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| loadStart | input | 1 | Load command pulse, taken only while idle |
| wideMode | input | 1 | 1 = each 16-bit value in a 4-byte slot; captured at load start |
| descPtr | input | 32 | Byte address of the first load record |
| descCount | input | 16 | Record count; only bits [4:0] select the number of records |
| loadBusy | output | 1 | High while a load is running |
| loadDone | output | 1 | One-cycle pulse when a load completes |
| memReq | output | 1 | Read request to memory |
| memAddr | output | 32 | Byte address of the requested word |
| memValid | input | 1 | Read data valid; completes the request |
| memRdata | input | 16 | Read data |
| dstAddr | input | 48 | Destination address to classify, byte 0 in bits [7:0] |
| modePromisc | input | 1 | Accept all individual addresses |
| modeAllMulti | input | 1 | Accept all group addresses |
| modeBcast | input | 1 | Accept the all-ones address |
| accept | output | 1 | Frame accepted |
| isMulti | output | 1 | Accepted by the all-multicast rule |
| isBcast | output | 1 | Accepted by the broadcast rule |
| ctrlInReset | input | 1 | Controller reset state; enables entry readback |
| camPtr | input | 4 | Entry index for readback |
| rdWordSel | input | 2 | 16-bit word of the entry to read back |
| rdData | output | 16 | Readback data |

## Verification
A wrong word counter or a wrong pointer step shows up as a bad address on `memAddr` within a few cycles of `loadStart`, so the bench logs every request address and compares the whole sequence. A wrong write index or byte lane only shows later, through entry readback or as a wrong accept on a destination that should match. A stale or misplaced enable mask shows only as a classification error. For this reason every load is followed by a full readback and by matches against both enabled and disabled entries. Priority faults in the classifier appear in the same cycle as the address, on the overlap cases: promiscuous mode with a group address, and multicast together with broadcast.

// File: rtl/addr_cam_pkg.sv
package addr_cam_pkg;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_CHECK = 2'd1,
    LD_REC   = 2'd2,
    LD_MASK  = 2'd3
  } ldState_t;

  // strobes from the load control to the table datapath
  typedef struct packed {
    logic       capture;   // latch pointer, count, mode; index to 0
    logic       wrWord;    // write memRdata into current entry slice
    logic       nextRec;   // step to next record
    logic       wrMask;    // load enable mask from memRdata
    logic [1:0] wordSel;   // word of the record being addressed
  } camStrobe_t;

endpackage

// File: rtl/addr_cam_ctrl.sv
module addr_cam_ctrl
  import addr_cam_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStart,
  input  logic       memValid,
  input  logic       countNz,
  input  logic       idxLast,
  output camStrobe_t stb,
  output logic       memReq,
  output logic       loadBusy,
  output logic       loadDone
);

  ldState_t   state, stateNxt;
  logic [1:0] wordCnt;

  always_comb begin
    stateNxt    = state;
    stb         = '0;
    stb.wordSel = wordCnt;
    memReq      = 1'b0;
    unique case (state)
      LD_IDLE: begin
        if (loadStart) begin
          stb.capture = 1'b1;
          stateNxt    = LD_CHECK;
        end
      end
      LD_CHECK: begin
        stateNxt = countNz ? LD_REC : LD_MASK;
      end
      LD_REC: begin
        memReq = 1'b1;
        if (memValid) begin
          stb.wrWord = 1'b1;
          if (wordCnt == 2'd3) begin
            stb.nextRec = 1'b1;
            stateNxt    = idxLast ? LD_MASK : LD_CHECK;
          end
        end
      end
      LD_MASK: begin
        memReq      = 1'b1;
        stb.wordSel = 2'd0;
        if (memValid) begin
          stb.wrMask = 1'b1;
          stateNxt   = LD_IDLE;
        end
      end
      default: stateNxt = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= LD_IDLE;
      wordCnt  <= 2'd1;
      loadDone <= 1'b0;
    end else begin
      state    <= stateNxt;
      loadDone <= stb.wrMask;
      if (state == LD_CHECK) begin
        wordCnt <= 2'd1;
      end else if (state == LD_REC && memValid) begin
        wordCnt <= wordCnt + 2'd1;
      end
    end
  end

  assign loadBusy = (state != LD_IDLE);

endmodule

// File: rtl/addr_cam_table.sv
module addr_cam_table
  import addr_cam_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int CNT_LOW     = 5,
  parameter int WORD_W      = 16,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int ENT_W      = 3 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  camStrobe_t        stb,
  input  logic              wideMode,
  input  logic [ADDR_W-1:0] descPtr,
  input  logic [CNT_W-1:0]  descCount,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              countNz,
  output logic              idxLast,
  input  logic [ENT_W-1:0]  dstAddr,
  output logic              camHit,
  input  logic              ctrlInReset,
  input  logic [IDX_W-1:0]  camPtr,
  input  logic [1:0]        rdWordSel,
  output logic [WORD_W-1:0] rdData
);

  logic [ADDR_W-1:0]      ptr;
  logic [CNT_W-1:0]       count;
  logic [IDX_W-1:0]       index;
  logic                   wideLat;
  logic [NUM_ENTRIES-1:0] camMask;
  logic [ENT_W-1:0]       camEntry [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [ADDR_W-1:0]      wordOff, recStep;

  // slot is 2 bytes narrow, 4 bytes wide; a record is 4 slots
  assign wordOff = wideLat ? (ADDR_W'(stb.wordSel) << 2) : (ADDR_W'(stb.wordSel) << 1);
  assign recStep = wideLat ? ADDR_W'(16) : ADDR_W'(8);
  assign memAddr = ptr + wordOff;
  assign countNz = |count[CNT_LOW-1:0];
  assign idxLast = (index == IDX_W'(NUM_ENTRIES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      count   <= '0;
      index   <= '0;
      wideLat <= 1'b0;
      camMask <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) camEntry[i] <= '0;
    end else begin
      if (stb.capture) begin
        ptr     <= descPtr;
        count   <= descCount;
        index   <= '0;
        wideLat <= wideMode;
      end
      if (stb.wrWord) begin
        unique case (stb.wordSel)
          2'd1:    camEntry[index][WORD_W-1:0]          <= memRdata;
          2'd2:    camEntry[index][2*WORD_W-1:WORD_W]   <= memRdata;
          default: camEntry[index][3*WORD_W-1:2*WORD_W] <= memRdata;
        endcase
      end
      if (stb.nextRec) begin
        ptr   <= ptr + recStep;
        count <= count - CNT_W'(1);
        index <= index + IDX_W'(1);
      end
      if (stb.wrMask) camMask <= memRdata[NUM_ENTRIES-1:0];
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gHit
    assign hitVec[g] = camMask[g] && (camEntry[g] == dstAddr);
  end
  assign camHit = |hitVec;

  always_comb begin
    rdData = '0;
    if (ctrlInReset) begin
      unique case (rdWordSel)
        2'd0:    rdData = camEntry[camPtr][WORD_W-1:0];
        2'd1:    rdData = camEntry[camPtr][2*WORD_W-1:WORD_W];
        2'd2:    rdData = camEntry[camPtr][3*WORD_W-1:2*WORD_W];
        default: rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/addr_cam_classify.sv
module addr_cam_classify #(
  parameter int ADDR_BYTES = 6,
  localparam int DST_W     = 8 * ADDR_BYTES
) (
  input  logic [DST_W-1:0] dstAddr,
  input  logic             modePromisc,
  input  logic             modeAllMulti,
  input  logic             modeBcast,
  input  logic             camHit,
  output logic             accept,
  output logic             isMulti,
  output logic             isBcast
);

  logic groupBit, allOnes;
  assign groupBit = dstAddr[0];
  assign allOnes  = &dstAddr;

  // fixed priority: promiscuous (individual only), all-multicast,
  // broadcast, then table match
  always_comb begin
    accept  = 1'b0;
    isMulti = 1'b0;
    isBcast = 1'b0;
    if (modePromisc && !groupBit) begin
      accept = 1'b1;
    end else if (modeAllMulti && groupBit) begin
      accept  = 1'b1;
      isMulti = 1'b1;
    end else if (modeBcast && allOnes) begin
      accept  = 1'b1;
      isBcast = 1'b1;
    end else if (camHit) begin
      accept = 1'b1;
    end
  end

endmodule

// File: rtl/addr_cam_filter.sv
module addr_cam_filter
  import addr_cam_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int CNT_LOW     = 5,
  localparam int WORD_W     = 16,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int DST_W      = 3 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStart,
  input  logic              wideMode,
  input  logic [ADDR_W-1:0] descPtr,
  input  logic [CNT_W-1:0]  descCount,
  output logic              loadBusy,
  output logic              loadDone,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [DST_W-1:0]  dstAddr,
  input  logic              modePromisc,
  input  logic              modeAllMulti,
  input  logic              modeBcast,
  output logic              accept,
  output logic              isMulti,
  output logic              isBcast,
  input  logic              ctrlInReset,
  input  logic [IDX_W-1:0]  camPtr,
  input  logic [1:0]        rdWordSel,
  output logic [WORD_W-1:0] rdData
);

  camStrobe_t stb;
  logic       countNz, idxLast, camHit;

  addr_cam_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadStart(loadStart),
    .memValid (memValid),
    .countNz  (countNz),
    .idxLast  (idxLast),
    .stb      (stb),
    .memReq   (memReq),
    .loadBusy (loadBusy),
    .loadDone (loadDone)
  );

  addr_cam_table #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .CNT_LOW    (CNT_LOW),
    .WORD_W     (WORD_W)
  ) u_table (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wideMode   (wideMode),
    .descPtr    (descPtr),
    .descCount  (descCount),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .countNz    (countNz),
    .idxLast    (idxLast),
    .dstAddr    (dstAddr),
    .camHit     (camHit),
    .ctrlInReset(ctrlInReset),
    .camPtr     (camPtr),
    .rdWordSel  (rdWordSel),
    .rdData     (rdData)
  );

  addr_cam_classify #(.ADDR_BYTES(DST_W / 8)) u_cls (
    .dstAddr     (dstAddr),
    .modePromisc (modePromisc),
    .modeAllMulti(modeAllMulti),
    .modeBcast   (modeBcast),
    .camHit      (camHit),
    .accept      (accept),
    .isMulti     (isMulti),
    .isBcast     (isBcast)
  );

endmodule

// File: rtl/addr_cam_filter_chk.sv
module addr_cam_filter_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int DST_W  = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadBusy,
  input logic              loadDone,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid,
  input logic [DST_W-1:0]  dstAddr,
  input logic              modePromisc,
  input logic              accept,
  input logic              isMulti,
  input logic              isBcast,
  input logic              ctrlInReset,
  input logic [WORD_W-1:0] rdData
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr)); // R14

  AST_REQ_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> loadBusy); // R14

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> !loadBusy); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone); // R5

  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isMulti, isBcast})); // R10

  AST_FLAG_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (isMulti || isBcast) |-> accept); // R12

  AST_PROMISC_UNI: assert property (@(posedge clk) disable iff (!rstN)
    modePromisc && !dstAddr[0] |-> accept && !isMulti && !isBcast); // R9

  AST_READ_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlInReset |-> rdData == '0); // R13

endmodule

bind addr_cam_filter addr_cam_filter_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DST_W(DST_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadBusy   (loadBusy),
  .loadDone   (loadDone),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memValid   (memValid),
  .dstAddr    (dstAddr),
  .modePromisc(modePromisc),
  .accept     (accept),
  .isMulti    (isMulti),
  .isBcast    (isBcast),
  .ctrlInReset(ctrlInReset),
  .rdData     (rdData)
);

// File: tb/sim_addr_cam_filter.sv
`timescale 1ns/1ps
module sim_addr_cam_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStart = 1'b0, wideMode = 1'b0;
  logic [31:0] descPtr = '0;
  logic [15:0] descCount = '0;
  logic        loadBusy, loadDone, memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [15:0] memRdata = '0;
  logic [47:0] dstAddr = '0;
  logic        modePromisc = 1'b0, modeAllMulti = 1'b0, modeBcast = 1'b0;
  logic        accept, isMulti, isBcast;
  logic        ctrlInReset = 1'b0;
  logic [3:0]  camPtr = '0;
  logic [1:0]  rdWordSel = '0;
  logic [15:0] rdData;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] reqLog [0:63];
  int          reqN = 0;
  logic [31:0] forceAddr = 32'hFFFF_FFFF, salt = '0;
  logic [15:0] forceVal = '0;
  logic [47:0] expEntry [0:15];
  logic [15:0] expMask = '0;

  always #5 clk = ~clk;

  addr_cam_filter u0 (.*);

  function automatic logic [15:0] memFn(logic [31:0] a);
    if (a == forceAddr) return forceVal;
    return 16'(((a ^ salt) * 32'h9E37_79B1) >> 13);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory responder: one word per request after 0..2 idle cycles
  initial begin : responder
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memValid) memValid = 1'b0;
      else if (memReq) begin
        if (waitCnt == 0) begin
          memRdata = memFn(memAddr);
          memValid = 1'b1;
          if (reqN < 64) reqLog[reqN] = memAddr;
          reqN++;
          waitCnt = int'($urandom % 3);
        end else waitCnt--;
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic doLoad(input bit wide, input logic [31:0] base, input logic [15:0] cnt,
                        input logic [15:0] maskVal, input bit midPulse, input string tag);
    int n, s, rs, k;
    bit seenDone;
    n  = (cnt[4:0] > 16) ? 16 : int'(cnt[4:0]);
    s  = wide ? 4 : 2;
    rs = 4 * s;
    salt      = $urandom;
    forceAddr = base + 32'(n * rs);
    forceVal  = maskVal;
    reqN = 0;
    @(negedge clk);
    wideMode = wide; descPtr = base; descCount = cnt; loadStart = 1'b1;
    @(negedge clk);
    loadStart = 1'b0;
    seenDone = 1'b0;
    for (int c = 0; c < 3000 && !seenDone; c++) begin
      @(negedge clk);
      if (midPulse && c == 8) loadStart = 1'b1;
      else loadStart = 1'b0;
      if (loadDone) seenDone = 1'b1;
    end
    chk(seenDone, {tag, " R5 done seen"}, 64'(seenDone), 64'd1);
    chk(!loadBusy, {tag, " R5 busy low at done"}, 64'(loadBusy), 64'd0);
    @(negedge clk);
    chk(!loadDone, {tag, " R5 done one cycle"}, 64'(loadDone), 64'd0);
    repeat (4) @(negedge clk);
    chk(!memReq && !loadBusy, {tag, " R14 idle after load"}, 64'({memReq, loadBusy}), 64'd0);
    chk(reqN == 3 * n + 1, {tag, " R3 request count"}, 64'(reqN), 64'(3 * n + 1));
    k = 0;
    for (int r = 0; r < n; r++) begin
      for (int w = 1; w <= 3; w++) begin
        logic [31:0] ea;
        ea = base + 32'(r * rs + w * s);
        if (k < reqN) chk(reqLog[k] == ea, {tag, wide ? " R4" : " R2", " record word address"},
                          64'(reqLog[k]), 64'(ea));
        k++;
      end
      expEntry[r] = {memFn(base + 32'(r * rs + 3 * s)), memFn(base + 32'(r * rs + 2 * s)),
                     memFn(base + 32'(r * rs + s))};
    end
    if (k < reqN) chk(reqLog[k] == forceAddr, {tag, " R5 mask address"}, 64'(reqLog[k]), 64'(forceAddr));
    expMask = maskVal;
  endtask

  task automatic checkTable(input string tag);
    ctrlInReset = 1'b1;
    for (int e = 0; e < 16; e++) begin
      for (int w = 0; w < 4; w++) begin
        logic [15:0] ev;
        camPtr = 4'(e); rdWordSel = 2'(w);
        ev = (w == 3) ? 16'h0 : expEntry[e][16*w +: 16];
        #1;
        chk(rdData == ev, {tag, " R13 entry readback"}, 64'(rdData), 64'(ev));
      end
    end
    ctrlInReset = 1'b0;
    #1;
    chk(rdData == 16'h0, {tag, " R13 readback gated"}, 64'(rdData), 64'd0);
  endtask

  function automatic logic [2:0] expClass(logic [47:0] d, bit p, bit am, bit b, output string tag);
    bit hit = 1'b0;
    for (int e = 0; e < 16; e++) if (expMask[e] && expEntry[e] == d) hit = 1'b1;
    if (p && !d[0])            begin tag = "R9";  return 3'b100; end
    if (am && d[0])            begin tag = "R10"; return 3'b110; end
    if (b && (&d))             begin tag = "R11"; return 3'b101; end
    if (hit)                   begin tag = "R12"; return 3'b100; end
    tag = "R8";
    return 3'b000;
  endfunction

  task automatic classify(input logic [47:0] d, input bit p, input bit am, input bit b, input string note);
    string tag;
    logic [2:0] ev;
    dstAddr = d; modePromisc = p; modeAllMulti = am; modeBcast = b;
    ev = expClass(d, p, am, b, tag);
    #1;
    chk({accept, isMulti, isBcast} == ev, {tag, " ", note}, 64'({accept, isMulti, isBcast}), 64'(ev));
  endtask

  initial begin : main
    logic [47:0] d;
    void'($urandom(32'h5EED_1234));
    for (int e = 0; e < 16; e++) expEntry[e] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!loadBusy && !loadDone && !memReq, "R1 idle after reset", 64'({loadBusy, loadDone, memReq}), 64'd0);
    classify(48'h0, 0, 0, 0, "R1 zero address rejected with mask clear");
    checkTable("R1");

    // narrow load, three records
    doLoad(1'b0, 32'h0000_1000, 16'h0003, 16'h0005, 1'b0, "L1");
    checkTable("L1 R2");
    classify(expEntry[0], 0, 0, 0, "R12 enabled entry 0 match");
    classify(expEntry[1], 0, 0, 0, "R8 disabled entry 1");
    classify(expEntry[2], 0, 0, 0, "R12 enabled entry 2 match");

    // wide load, low five count bits = 2, upper bits ignored
    doLoad(1'b1, 32'h2000_0040, 16'h0022, 16'h0006, 1'b0, "L2 R4");
    checkTable("L2 R6");
    classify(expEntry[2], 0, 0, 0, "R6 kept entry 2 enabled");
    classify(expEntry[0], 0, 0, 0, "R8 new entry 0 disabled");

    // zero records: mask read at pointer
    doLoad(1'b0, 32'h0000_3000, 16'h0040, 16'hFFFF, 1'b0, "L3 R3");
    checkTable("L3 R3");

    // overlong load with an ignored second start
    doLoad(1'b0, 32'h0000_4000, 16'h0014, 16'hA5A5, 1'b1, "L4 R7 R14");
    checkTable("L4 R7");

    // directed priority corners
    classify(48'h0000_1234_5602, 1, 0, 0, "R9 promiscuous unicast");
    classify(48'h0000_1234_5603, 1, 0, 0, "R9 promiscuous does not take group");
    classify(48'h0000_1234_5603, 0, 1, 0, "R10 all-multicast");
    classify(48'hFFFF_FFFF_FFFF, 0, 1, 1, "R10 multicast over broadcast");
    classify(48'hFFFF_FFFF_FFFF, 0, 0, 1, "R11 broadcast");
    classify(48'hFFFF_FFFF_FFFD + 48'd2 - 48'd2 - 48'd2, 0, 0, 1, "R11 near-broadcast group");
    classify(expEntry[0], 0, 0, 0, "R12 enabled entry 0");
    classify(expEntry[1], 0, 0, 0, "R8 disabled entry 1");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int pick;
      pick = int'($urandom % 4);
      if (pick == 0)      d = expEntry[$urandom % 16];
      else if (pick == 1) d = 48'hFFFF_FFFF_FFFF;
      else                d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      classify(d, 1'($urandom), 1'($urandom), 1'($urandom), "random mix");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule